// File: doc/BRIEF.md
# Paired PWM Edge Generator with Dead Band

This block turns the value of a shared period counter into a pair of PWM pins, A and B. Two compare values are held for each period. The first is a lead delay: the count at which the pulse on A starts. The second is a length: the number of counts the pulse stays active.

- A lead delay of zero gives edge-aligned pulses.
- A non-zero lead delay places the pulse anywhere in the period, so centered or asymmetric shapes come out of the same logic.

Pin B either copies A or carries its inverse.

When B carries the inverse, a dead band can be inserted:

- Each output's change from inactive to active is held back by four counter clocks per step of a 4-bit code.
- The change from active to inactive is not delayed.
- As a result, the two outputs are never active together.

Each pin has its own output polarity and its own idle level. The idle level is the pin value driven while the counter is stopped. The counter itself, any prescaler and register access sit outside this block. The block only watches the count, a run flag and a wrap strobe.

Top module: `pwm_pair_top`

## Requirements
- R1: While running, the internal request for A is active in every cycle whose count c satisfies lead <= c < lead + length. The arithmetic carries one extra bit, so lead + length never wraps. A length of zero never activates; lead 0 with length equal to the period keeps A active.
- R2: Each pin is registered. The pin level seen after the clock edge at which count c was presented reflects c, which is one cycle of latency.
- R3: With `comp_en` low, the active state of B always equals that of A, and the dead band code has no effect.
- R4: With `comp_en` high and `dead_code` 0, B's request is the inverse of A's request in every running cycle.
- R5: With `comp_en` high and `dead_code` = k > 0, each output turns active only after its request has been active for 4*k consecutive cycles, that is on the (4k+1)-th cycle. It turns inactive in the same cycle its request drops.
- R6: A request run shorter than or equal to 4*k cycles leaves that output inactive for the whole run.
- R7: With `comp_en` high, A and B are never active in the same cycle.
- R8: Pin level = active XOR polarity bit; a polarity bit of 1 means the output is low-true.
- R9: While `cnt_run` is low, `pwm_a` follows `idle_a` and `pwm_b` follows `idle_b`, regardless of polarity, one cycle later. During reset both pins are 0. On resume, the dead band count restarts from zero.
- R10: Lead and length are sampled into shadow registers only at the edge where `cnt_wrap` is high, or at any edge while `cnt_run` is low. A change in mid-period takes effect from count 0 of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_run | input | 1 | Shared counter is running |
| cnt_wrap | input | 1 | Counter is at its last count of the period |
| cnt_val | input | CNT_W | Current counter value |
| lead_dly | input | CNT_W | Count at which the pulse starts |
| duty_len | input | CNT_W | Pulse length in counts |
| comp_en | input | 1 | 1: B is the inverse of A; 0: B copies A |
| dead_code | input | DT_W | Dead band in steps of 4 clocks, 0 = off |
| pol_lo_a | input | 1 | A is low-true |
| pol_lo_b | input | 1 | B is low-true |
| idle_a | input | 1 | Level of A while stopped |
| idle_b | input | 1 | Level of B while stopped |
| pwm_a | output | 1 | PWM pin A |
| pwm_b | output | 1 | PWM pin B |

## Verification
Two events can fall in the same cycle here.

The first pair is a shadow reload and a live edge decision. At the wrap edge, the request still uses the old compare values while the new ones are latched. The bench changes the length in mid-period. It then checks that the current period keeps the old pulse width and that the next period shows the new one.

The second pair is one output's undelayed fall and the other output's delayed rise. Pulse counts measured over whole periods, with wrap-spanning requests, show whether only the rising transitions lose 4*k cycles. A checker also requires the opposite output to have been quiet for at least four cycles before any delayed rise.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
    // counter clocks per dead band step
    localparam int DT_STEP = 4;

    function automatic int dead_cnt_w(input int dt_w);
        return $clog2(((2 ** dt_w) - 1) * DT_STEP + 1);
    endfunction
endpackage

// File: rtl/pwm_pair_edge.sv
module pwm_pair_edge #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] lead_in,
    input  logic [CNT_W-1:0] len_in,
    output logic             req
);
    typedef struct packed {
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] len;
    } shadow_t;

    shadow_t    shd_d, shd_q;
    logic [CNT_W:0] stop_pt;

    always_comb begin
        shd_d = shd_q;
        if (load_en) begin
            shd_d.lead = lead_in;
            shd_d.len  = len_in;
        end
    end

    // one extra bit so lead + length never wraps
    assign stop_pt = {1'b0, shd_q.lead} + {1'b0, shd_q.len};
    assign req = ({1'b0, cnt_val} >= {1'b0, shd_q.lead}) &&
                 ({1'b0, cnt_val} < stop_pt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shd_q <= '0;
        else        shd_q <= shd_d;
    end
endmodule

// File: rtl/pwm_pair_deadband.sv
module pwm_pair_deadband #(
    parameter int DCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              req,
    input  logic              dt_en,
    input  logic [DCNT_W-1:0] dt_cycles,
    input  logic              idle_lvl,
    input  logic              pol_lo,
    output logic              pin
);
    typedef struct packed {
        logic [DCNT_W-1:0] cnt;
        logic              pin;
    } db_t;

    db_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.pin = idle_lvl;
        end else if (!req) begin
            st_d.cnt = '0;
            st_d.pin = pol_lo;          // inactive level
        end else if (!dt_en || (st_q.cnt >= dt_cycles)) begin
            st_d.pin = ~pol_lo;         // active level
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.pin = pol_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.pin;
endmodule

// File: rtl/pwm_pair_top.sv
module pwm_pair_top
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_run,
    input  logic             cnt_wrap,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] lead_dly,
    input  logic [CNT_W-1:0] duty_len,
    input  logic             comp_en,
    input  logic [DT_W-1:0]  dead_code,
    input  logic             pol_lo_a,
    input  logic             pol_lo_b,
    input  logic             idle_a,
    input  logic             idle_b,
    output logic             pwm_a,
    output logic             pwm_b
);
    localparam int DCNT_W = dead_cnt_w(DT_W);

    logic              req_main;
    logic [1:0]        req_pair;
    logic [1:0]        idle_pair;
    logic [1:0]        pol_pair;
    logic [1:0]        pin_pair;
    logic              dt_en;
    logic [DCNT_W-1:0] dt_cycles;

    pwm_pair_edge #(.CNT_W(CNT_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (cnt_wrap || !cnt_run),
        .cnt_val (cnt_val),
        .lead_in (lead_dly),
        .len_in  (duty_len),
        .req     (req_main)
    );

    assign dt_en     = comp_en && (dead_code != '0);
    assign dt_cycles = DCNT_W'(dead_code) * DCNT_W'(DT_STEP);
    assign req_pair  = {comp_en ? ~req_main : req_main, req_main};
    assign idle_pair = {idle_b, idle_a};
    assign pol_pair  = {pol_lo_b, pol_lo_a};

    for (genvar g = 0; g < 2; g++) begin : g_out
        pwm_pair_deadband #(.DCNT_W(DCNT_W)) u_db (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (cnt_run),
            .req       (req_pair[g]),
            .dt_en     (dt_en),
            .dt_cycles (dt_cycles),
            .idle_lvl  (idle_pair[g]),
            .pol_lo    (pol_pair[g]),
            .pin       (pin_pair[g])
        );
    end

    assign pwm_a = pin_pair[0];
    assign pwm_b = pin_pair[1];
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
    parameter int DT_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cnt_run,
    input logic            comp_en,
    input logic [DT_W-1:0] dead_code,
    input logic            pol_lo_a,
    input logic            pol_lo_b,
    input logic            idle_a,
    input logic            idle_b,
    input logic            pwm_a,
    input logic            pwm_b
);
    logic            act_a, act_b;
    logic [2:0]      cfg_q, qa_q, qb_q;
    logic [DT_W+2:0] prev_q;
    logic            cfg_ok;

    assign act_a  = pwm_a ^ pol_lo_a;
    assign act_b  = pwm_b ^ pol_lo_b;
    assign cfg_ok = cnt_run && comp_en && (dead_code != '0) &&
                    ({comp_en, pol_lo_a, pol_lo_b, dead_code} == prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            qa_q   <= '0;
            qb_q   <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= {comp_en, pol_lo_a, pol_lo_b, dead_code};
            cfg_q  <= !cfg_ok ? 3'd0 : (cfg_q == 3'd7 ? cfg_q : cfg_q + 3'd1);
            qa_q   <= act_a ? 3'd0 : (qa_q == 3'd7 ? qa_q : qa_q + 3'd1);
            qb_q   <= act_b ? 3'd0 : (qb_q == 3'd7 ? qb_q : qb_q + 3'd1);
        end
    end

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_run && comp_en) |=> !((pwm_a ^ $past(pol_lo_a)) && (pwm_b ^ $past(pol_lo_b)))); // R7

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_run |=> (pwm_a == $past(idle_a)) && (pwm_b == $past(idle_b))); // R9

    AST_SAME_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_run && !comp_en) |=> ((pwm_a ^ $past(pol_lo_a)) == (pwm_b ^ $past(pol_lo_b)))); // R3

    AST_DEAD_GAP_A: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q >= 3'd6 && $stable(pol_lo_a) && $stable(pol_lo_b) && $rose(act_a))
        |-> (!act_b && qb_q >= 3'd4)); // R5

    AST_DEAD_GAP_B: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q >= 3'd6 && $stable(pol_lo_a) && $stable(pol_lo_b) && $rose(act_b))
        |-> (!act_a && qa_q >= 3'd4)); // R5
endmodule

bind pwm_pair_top pwm_pair_chk #(.DT_W(DT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_run   (cnt_run),
    .comp_en   (comp_en),
    .dead_code (dead_code),
    .pol_lo_a  (pol_lo_a),
    .pol_lo_b  (pol_lo_b),
    .idle_a    (idle_a),
    .idle_b    (idle_b),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b)
);

// File: tb/pwm_pair_top_tb_top.sv
module pwm_pair_top_tb_top;
    localparam int P = 20;
    // lead, length, comp, dead code, expected A active, expected B active
    localparam int TBL [9][6] = '{
        '{0, 5, 0, 0, 5, 5},
        '{5, 10, 0, 0, 10, 10},
        '{5, 10, 1, 0, 10, 10},
        '{5, 10, 1, 1, 6, 6},
        '{0, 8, 1, 2, 0, 4},
        '{2, 6, 0, 3, 6, 6},
        '{0, 20, 1, 1, 20, 0},
        '{0, 0, 1, 0, 0, 20},
        '{3, 4, 1, 15, 0, 0}
    };

    logic clk = 0, rst_n = 0, cnt_run = 0, cnt_wrap = 0;
    logic [15:0] cnt_val = 0, lead_dly = 0, duty_len = 0;
    logic comp_en = 0, pol_lo_a = 0, pol_lo_b = 0, idle_a = 0, idle_b = 0;
    logic [3:0] dead_code = 0;
    logic pwm_a, pwm_b;
    int total = 0, bad = 0;
    int na, nb, fa;
    bit finished = 0;

    always #5 clk = ~clk;

    pwm_pair_top dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_run(cnt_run), .cnt_wrap(cnt_wrap),
        .cnt_val(cnt_val), .lead_dly(lead_dly), .duty_len(duty_len),
        .comp_en(comp_en), .dead_code(dead_code), .pol_lo_a(pol_lo_a),
        .pol_lo_b(pol_lo_b), .idle_a(idle_a), .idle_b(idle_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one period; counts active cycles, first active index of A;
    // optional length change right after count chg_at is sampled
    task automatic run_period(input int chg_at, input int chg_w);
        na = 0; nb = 0; fa = -1;
        for (int c = 0; c < P; c++) begin
            cnt_val  = 16'(c);
            cnt_wrap = (c == P - 1);
            @(negedge clk);
            if (pwm_a ^ pol_lo_a) begin
                na++;
                if (fa < 0) fa = c;
            end
            if (pwm_b ^ pol_lo_b) nb++;
            if (c == chg_at) duty_len = 16'(chg_w);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_a = 1; idle_b = 0;
        repeat (2) @(negedge clk);
        check("R9 reset a", int'(pwm_a), 0);
        check("R9 reset b", int'(pwm_b), 0);
        rst_n = 1;
        @(negedge clk);
        check("R9 idle a", int'(pwm_a), 1);
        check("R9 idle b", int'(pwm_b), 0);

        cnt_run = 1;
        for (int i = 0; i < 9; i++) begin
            lead_dly = 16'(TBL[i][0]); duty_len = 16'(TBL[i][1]);
            comp_en = TBL[i][2][0]; dead_code = 4'(TBL[i][3]);
            run_period(-1, 0);
            run_period(-1, 0);
            run_period(-1, 0);
            check($sformatf("R1/R3/R4/R5/R6 row%0d a", i), na, TBL[i][4]);
            check($sformatf("R1/R3/R4/R5/R6 row%0d b", i), nb, TBL[i][5]);
            if (i == 1) check("R2 first active count", fa, 5);
        end

        // low-true output on A
        lead_dly = 0; duty_len = 5; comp_en = 0; dead_code = 0; pol_lo_a = 1;
        run_period(-1, 0); run_period(-1, 0);
        check("R8 low-true active cycles", na, 5);
        check("R8 low-true pin high cycles", P - na, 15);
        pol_lo_a = 0;

        // mid-period change waits for wrap
        run_period(10, 15);
        check("R10 old length kept", na, 5);
        run_period(-1, 0);
        check("R10 new length at next period", na, 15);

        // idle level ignores polarity; paused load
        cnt_run = 0; idle_a = 0; idle_b = 1; pol_lo_a = 1; duty_len = 7;
        @(negedge clk);
        check("R9 paused a", int'(pwm_a), 0);
        check("R9 paused b", int'(pwm_b), 1);
        pol_lo_a = 0;
        @(negedge clk);
        cnt_run = 1;
        run_period(-1, 0);
        check("R10 load while paused", na, 7);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule